// File: doc/BRIEF.md
# Indexed Performance Counter Bank

A bank of event counters that software reaches through a narrow register window. A selector register names one counter. Every per-counter register in the window acts on that counter: its event condition, the low and high halves of its count, and a snapshot of its full value. Each counter chooses one condition from a vector of per-cycle event pulses. A counter is stopped by giving it condition 0, which never fires, so there is no separate start or stop bit. A single enable bit in the control register gates all counters together.

Counters are wider than the 32-bit bus. Software can read a counter without tearing: it sets the snapshot bit in the control register, which copies the selected counter into a pair of holding registers in one cycle, and then reads the two halves of the copy. A read-only information register reports that the bank is present, how many counters it has, the size code that sets their width, and how many condition numbers exist. Software clears a counter by writing 0 to its condition and then 0 to both count halves.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset all counts, all condition fields, the selector and the enable bit are zero, and reads of the control, selector, condition, count and snapshot registers return 0.
- R2: Address 1 is the selector (8 bits). Condition (address 2), count-low (address 3), count-high (address 4) and snapshot capture act only on the counter the selector names.
- R3: With the enable set, a counter whose condition c is in 1..16 adds 1 on every clock edge at which event_i[c-1] is high. Other counters do not see that event.
- R4: A counter with condition 0, or with any condition above 16, never changes unless its count is written.
- R5: With control bit 0 (enable) clear, no counter changes on any event.
- R6: A write to count-low sets count bits [31:0], and a write to count-high sets bits [47:32] from wdata[15:0]. In the same cycle the write takes priority over an increment.
- R7: Writing the control register (address 0) with bit 1 set copies the selected counter's value from before that edge into snapshot-low (address 5, bits [31:0]) and snapshot-high (address 6, bits [47:32]). The copy then holds while the counter keeps running.
- R8: A counter at 2^48-1 that takes an increment becomes 0.
- R9: When the selector holds a value of 4 or more, condition and count reads return 0, condition and count writes change no counter, and a snapshot captures 0.
- R10: The information register (address 7) reads bit 0 = 1 (present), bits [15:8] = counter count (4), bits [19:16] = size code s = 1 (width 32+16*s), bits [31:24] = condition count (17). All other bits are 0.
- R11: A control read returns the enable in bit 0. The snapshot bit and bits [31:16] read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| event_i | input | 16 | Per-cycle event condition pulses |

## Verification
The hardest cases to reach are collisions at a single clock edge: an event pulse that lands in the same cycle as a count write, and one that lands in the same cycle as a snapshot request. Only the edge ordering of these cases tells a correct design from a wrong one. The stimulus raises the chosen event line together with the write strobe, so that both are seen at exactly one edge, and then lowers the line before reading back. The expected value is therefore one off from what a design with the wrong priority would give. The wrap case is reached by preloading all ones through both halves and then allowing one event cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    REG_CTRL    = 3'd0,
    REG_SEL     = 3'd1,
    REG_COND    = 3'd2,
    REG_CNT_LO  = 3'd3,
    REG_CNT_HI  = 3'd4,
    REG_SNAP_LO = 3'd5,
    REG_SNAP_HI = 3'd6,
    REG_INFO    = 3'd7
  } reg_addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SNAP_BIT = 1;
  localparam int SEL_W         = 8;
  localparam int CFG_W         = 8;
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int CNT_W      = 48,
  parameter int NUM_EVENTS = 16,
  parameter int CFG_W      = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [NUM_EVENTS-1:0] event_i,
  input  logic                  cfg_we_i,
  input  logic                  lo_we_i,
  input  logic                  hi_we_i,
  input  logic [31:0]           wdata_i,
  output logic [CFG_W-1:0]      cfg_o,
  output logic [CNT_W-1:0]      cnt_o
);
  localparam int HI_W = CNT_W - 32;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sel_evt, hit;

  // condition c selects event c-1; 0 and out-of-range never fire
  always_comb begin
    sel_evt = 1'b0;
    for (int e = 0; e < NUM_EVENTS; e++) begin
      if (cfg_q == CFG_W'(e + 1)) sel_evt = event_i[e];
    end
    hit = en_i & sel_evt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      if (cfg_we_i) cfg_q <= wdata_i[CFG_W-1:0];
      if (lo_we_i)      cnt_q[31:0]       <= wdata_i;
      else if (hi_we_i) cnt_q[CNT_W-1:32] <= wdata_i[HI_W-1:0];
      else if (hit)     cnt_q             <= cnt_q + ONE;
    end
  end

  assign cfg_o = cfg_q;
  assign cnt_o = cnt_q;

  assert_never_cond_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lo_we_i && !hi_we_i && cfg_q == '0) |=> $stable(cnt_q));
  assert_step_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lo_we_i && !hi_we_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE));
  assert_gated_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !lo_we_i && !hi_we_i) |=> $stable(cnt_q));
  assert_wrap_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lo_we_i && !hi_we_i && hit && (&cnt_q)) |=> cnt_q == '0);
  assert_write_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i |=> cnt_q[31:0] == $past(wdata_i));
endmodule

// File: rtl/pmc_snapshot.sv
module pmc_snapshot #(
  parameter int CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] val_i,
  output logic [CNT_W-1:0] snap_o
);
  logic [CNT_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    snap_q <= '0;
    else if (cap_i) snap_q <= val_i;
  end

  assign snap_o = snap_q;

  assert_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> snap_q == $past(val_i));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(snap_q));
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pmc_pkg::*;
#(
  parameter int NUM_CNT    = 4,
  parameter int SIZE_SEL   = 1,
  parameter int NUM_EVENTS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_we_i,
  input  logic [2:0]            bus_addr_i,
  input  logic [31:0]           bus_wdata_i,
  output logic [31:0]           bus_rdata_o,
  input  logic [NUM_EVENTS-1:0] event_i
);
  localparam int CNT_W    = 32 + 16 * SIZE_SEL;
  localparam int HI_W     = CNT_W - 32;
  localparam int NUM_COND = NUM_EVENTS + 1;
  localparam int IDX_W    = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam logic [31:0] INFO_VAL =
    {8'(NUM_COND), 4'b0, 4'(SIZE_SEL), 8'(NUM_CNT), 7'b0, 1'b1};

  logic [SEL_W-1:0] sel_q;
  logic             en_q;
  logic             sel_ok;
  logic [IDX_W-1:0] sel_idx;
  logic             wr_ctrl, wr_cond, wr_lo, wr_hi, snap_cap;
  logic [CFG_W-1:0] cfg_a [NUM_CNT];
  logic [CNT_W-1:0] cnt_a [NUM_CNT];
  logic [CFG_W-1:0] sel_cfg;
  logic [CNT_W-1:0] sel_cnt, snap_val;

  assign sel_ok   = sel_q < SEL_W'(NUM_CNT);
  assign sel_idx  = sel_q[IDX_W-1:0];
  assign wr_ctrl  = bus_we_i && bus_addr_i == REG_CTRL;
  assign wr_cond  = bus_we_i && bus_addr_i == REG_COND && sel_ok;
  assign wr_lo    = bus_we_i && bus_addr_i == REG_CNT_LO && sel_ok;
  assign wr_hi    = bus_we_i && bus_addr_i == REG_CNT_HI && sel_ok;
  assign snap_cap = wr_ctrl && bus_wdata_i[CTRL_SNAP_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (bus_we_i && bus_addr_i == REG_SEL) sel_q <= bus_wdata_i[SEL_W-1:0];
      if (wr_ctrl) en_q <= bus_wdata_i[CTRL_EN_BIT];
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic hit_sel;
    assign hit_sel = sel_idx == IDX_W'(g);

    pmc_counter #(
      .CNT_W(CNT_W), .NUM_EVENTS(NUM_EVENTS), .CFG_W(CFG_W)
    ) i_counter (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_q),
      .event_i  (event_i),
      .cfg_we_i (wr_cond && hit_sel),
      .lo_we_i  (wr_lo && hit_sel),
      .hi_we_i  (wr_hi && hit_sel),
      .wdata_i  (bus_wdata_i),
      .cfg_o    (cfg_a[g]),
      .cnt_o    (cnt_a[g])
    );

    assert_oob_cfg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && !sel_ok) |=> $stable(cfg_a[g]));
  end

  assign sel_cfg = sel_ok ? cfg_a[sel_idx] : '0;
  assign sel_cnt = sel_ok ? cnt_a[sel_idx] : '0;

  pmc_snapshot #(.CNT_W(CNT_W)) i_snapshot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (snap_cap),
    .val_i  (sel_cnt),
    .snap_o (snap_val)
  );

  always_comb begin
    unique case (bus_addr_i)
      REG_CTRL:    bus_rdata_o = {31'b0, en_q};
      REG_SEL:     bus_rdata_o = 32'(sel_q);
      REG_COND:    bus_rdata_o = 32'(sel_cfg);
      REG_CNT_LO:  bus_rdata_o = sel_cnt[31:0];
      REG_CNT_HI:  bus_rdata_o = 32'(sel_cnt[CNT_W-1:32]);
      REG_SNAP_LO: bus_rdata_o = snap_val[31:0];
      REG_SNAP_HI: bus_rdata_o = 32'(snap_val[CNT_W-1:32]);
      default:     bus_rdata_o = INFO_VAL;
    endcase
  end

  assert_oob_snap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_cap && !sel_ok) |=> snap_val == '0);
  assert_ctrl_upper_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == REG_CTRL) |-> bus_rdata_o[31:1] == '0);
  assert_hi_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == REG_CNT_HI) |-> bus_rdata_o[31:HI_W] == '0);
endmodule

// File: tb/test_perf_counter_bank.sv
module test_perf_counter_bank;
  localparam logic [2:0] A_CTRL = 3'd0, A_SEL = 3'd1, A_COND = 3'd2,
    A_LO = 3'd3, A_HI = 3'd4, A_SLO = 3'd5, A_SHI = 3'd6, A_INFO = 3'd7;

  typedef struct {
    logic [31:0] exp;
    int          req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] ev = '0;
  item_t       q[$];
  item_t       cur;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  perf_counter_bank i_perf_counter_bank (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .event_i(ev)
  );

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input int r);
    item_t it;
    it.exp = e; it.req = r;
    q.push_back(it);
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] v, input int n);
    ev = v;
    repeat (n) @(posedge clk);
    #1 ev = '0;
  endtask

  // monitor: compare each read against the queued expectation
  always @(negedge clk) begin
    if (rd_en) begin
      cur = q.pop_front();
      n_chk++;
      if (rdata !== cur.exp) begin
        n_bad++;
        $display("FAIL R%0d addr=%0d actual=%h expected=%h", cur.req, addr, rdata, cur.exp);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(A_CTRL, 0, 1); rd(A_SEL, 0, 1); rd(A_COND, 0, 1);
    rd(A_LO, 0, 1); rd(A_HI, 0, 1); rd(A_SLO, 0, 1); rd(A_SHI, 0, 1);
    // R10 information register
    rd(A_INFO, 32'h1101_0401, 10);
    // configure: c0 cond1, c1 cond16, c2 cond0, c3 cond17
    wr(A_SEL, 0); wr(A_COND, 1);
    wr(A_SEL, 1); wr(A_COND, 16);
    wr(A_SEL, 2); wr(A_COND, 0);
    wr(A_SEL, 3); wr(A_COND, 17);
    wr(A_CTRL, 1);
    rd(A_CTRL, 1, 11);              // R11
    pulse(16'hFFFF, 3);
    wr(A_SEL, 0); rd(A_LO, 3, 3);   // R3
    wr(A_SEL, 1); rd(A_LO, 3, 3);   // R3 top event line
    rd(A_COND, 16, 2);              // R2
    wr(A_SEL, 2); rd(A_LO, 0, 4);   // R4 condition 0
    wr(A_SEL, 3); rd(A_LO, 0, 4);   // R4 condition above range
    pulse(16'h0001, 2);
    wr(A_SEL, 0); rd(A_LO, 5, 3);   // R3 only event 0
    wr(A_SEL, 1); rd(A_LO, 3, 3);   // R3 other counter unaffected
    // R5 global disable
    wr(A_CTRL, 0);
    pulse(16'hFFFF, 4);
    wr(A_SEL, 0); rd(A_LO, 5, 5);
    rd(A_CTRL, 0, 5);
    // R6 write beats increment in same cycle
    wr(A_CTRL, 1);
    ev = 16'h0001;
    wr(A_LO, 100);
    ev = '0;
    rd(A_LO, 100, 6);
    wr(A_HI, 32'hFFFF_ABCD);
    rd(A_HI, 32'h0000_ABCD, 6);
    rd(A_LO, 100, 6);
    // R8 wrap
    wr(A_LO, 32'hFFFF_FFFF); wr(A_HI, 32'h0000_FFFF);
    pulse(16'h0001, 1);
    rd(A_LO, 0, 8); rd(A_HI, 0, 8);
    // R7 snapshot sees pre-increment value
    wr(A_LO, 500); wr(A_HI, 32'h12);
    ev = 16'h0001;
    wr(A_CTRL, 3);
    ev = '0;
    rd(A_SLO, 500, 7); rd(A_SHI, 32'h12, 7); rd(A_LO, 501, 7);
    rd(A_CTRL, 1, 11);              // R11 snapshot bit reads 0
    pulse(16'h0001, 2);
    rd(A_SLO, 500, 7); rd(A_LO, 503, 7);
    // R2 snapshot follows the selector
    wr(A_SEL, 1); wr(A_CTRL, 3);
    rd(A_SLO, 3, 2); rd(A_SHI, 0, 2);
    // R9 selector out of range
    wr(A_SEL, 6);
    wr(A_COND, 1); wr(A_LO, 77); wr(A_HI, 5);
    rd(A_SEL, 6, 2);
    rd(A_COND, 0, 9); rd(A_LO, 0, 9); rd(A_HI, 0, 9);
    wr(A_CTRL, 3);
    rd(A_SLO, 0, 9);
    wr(A_SEL, 0); rd(A_LO, 503, 9); rd(A_COND, 1, 9);
    wr(A_SEL, 2); rd(A_COND, 0, 9); rd(A_LO, 0, 9);
    // R1-style clear sequence on counter 0
    wr(A_SEL, 0); wr(A_COND, 0); wr(A_LO, 0); wr(A_HI, 0);
    pulse(16'hFFFF, 2);
    rd(A_LO, 0, 4); rd(A_HI, 0, 4);
    @(posedge clk); #1;
    if (q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R1 pending reads actual=%0d expected=0", q.size());
    end
    finish_run();
  end
endmodule